// File: doc/BRIEF.md
# Machine Security Configuration and Protection-Entry Write Guard

This block holds the machine-level security configuration register that sets how the memory protection unit behaves. The register has three live bits: a lockdown bit that changes what the lock flag in an entry means, an allowlist bit that makes machine-mode accesses with no matching rule fail, and a bypass bit that lets software edit locked entries, for example during boot. The three bits are outputs that the access checker consumes. The lockdown and allowlist bits can each be built as tied low, tied high, or sticky. The bypass bit can be built as writable or as always zero.

The block also sits on the CSR write path of the protection entries. For every configuration-byte or address write it decides whether the per-entry write strobe fires. The decision uses the current configuration bytes of the entries and the security bits. In lockdown mode the guard drops writes that would create an executable rule that the mode forbids. Outside lockdown mode it rewrites the reserved write-without-read encoding.

Entry `i` has its configuration byte at CSR `CFG_BASE+i` and its address register at CSR `ADDR_BASE+i`. A configuration byte uses these bit positions: bit 0 is read (R), bit 1 is write (W), bit 2 is execute (X), bits 4:3 are the address-match mode, and bit 7 is the lock flag (L).

Top module: `sec_cfg_lock`

## Requirements
- R1: After hard reset, a sticky or writable security bit reads 0.
- R2: A machine-mode write to CSR `SEC_ADDR` sets the lockdown bit if data bit 0 is 1, and sets the allowlist bit if data bit 1 is 1. A later write with 0 in either bit does not clear that bit.
- R3: A bit built as tied low reads 0 and a bit built as tied high reads 1, whatever is written. The bypass bit reads 0 when it is built as non-writable.
- R4: When no entry has L=1, the bypass bit follows data bit 2 of a machine-mode `SEC_ADDR` write, both to set it and to clear it. While the bypass bit is 0 and any entry has L=1 (bit 7), a write that tries to set bypass leaves it at 0.
- R5: A write to any decoded address (`SEC_ADDR`, `CFG_BASE+i` or `ADDR_BASE+i`) with privilege other than 2'b11 raises `illegal` in that cycle. Such a write fires no strobe and changes no security bit.
- R6: While bypass is 0, configuration and address writes to an entry whose current byte has L=1 fire no strobe. While bypass is 1, these writes are accepted.
- R7: While lockdown is 1 and bypass is 0, a configuration write is dropped if its new byte has LRWX equal to 1001, 1010, 1011 or 1101. Every other LRWX value is accepted, 1111 included. While bypass is 1, none of these writes is dropped.
- R8: While lockdown is 0, a new byte with R=0 and W=1 is forwarded on `cfg_wbyte` with W cleared. While lockdown is 1, the byte is forwarded unchanged.
- R9: An accepted write to `CFG_BASE+i` pulses only `cfg_we[i]`, and an accepted write to `ADDR_BASE+i` pulses only `addr_we[i]`. At most one strobe is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low hard reset |
| csr_we | input | 1 | CSR write request |
| csr_addr | input | 12 | CSR address |
| csr_wdata | input | XLEN | CSR write data |
| csr_priv | input | 2 | Privilege of the writer, 2'b11 is machine |
| entry_cfg | input | 8*NUM_ENTRIES | Current configuration bytes, entry i in bits 8i+7:8i |
| sec_lockdown | output | 1 | Lockdown bit |
| sec_allowlist | output | 1 | Allowlist-policy bit |
| sec_bypass | output | 1 | Lock-bypass bit |
| cfg_we | output | NUM_ENTRIES | Per-entry configuration write strobe |
| cfg_wbyte | output | 8 | Configuration byte to store |
| addr_we | output | NUM_ENTRIES | Per-entry address write strobe |
| illegal | output | 1 | Non-machine write to a decoded address |

## Verification
The bench builds two instances from the same stimulus. The first uses the defaults: both policy bits sticky, bypass writable, and eight entries. This build covers the sticky behaviour, the bypass freeze and the full 16-value LRWX filter under lockdown. The second ties lockdown high, ties allowlist low and makes bypass non-writable, so writes of all ones can be shown to leave those three bits at their built-in values.

// File: rtl/sec_cfg_lock.sv
module sec_cfg_lock #(
  parameter int          NUM_ENTRIES     = 8,
  parameter int          XLEN            = 64,
  parameter int          LOCKDOWN_MODE   = 2,
  parameter int          ALLOWLIST_MODE  = 2,
  parameter bit          BYPASS_WRITABLE = 1'b1,
  parameter logic [11:0] SEC_ADDR        = 12'h747,
  parameter logic [11:0] CFG_BASE        = 12'h3A0,
  parameter logic [11:0] ADDR_BASE       = 12'h3B0
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     csr_we,
  input  logic [11:0]              csr_addr,
  input  logic [XLEN-1:0]          csr_wdata,
  input  logic [1:0]               csr_priv,
  input  logic [8*NUM_ENTRIES-1:0] entry_cfg,
  output logic                     sec_lockdown,
  output logic                     sec_allowlist,
  output logic                     sec_bypass,
  output logic [NUM_ENTRIES-1:0]   cfg_we,
  output logic [7:0]               cfg_wbyte,
  output logic [NUM_ENTRIES-1:0]   addr_we,
  output logic                     illegal
);
  localparam int MODE_ZERO = 0;
  localparam int MODE_ONE  = 1;

  logic [NUM_ENTRIES-1:0] locked, cfg_hit, addr_hit;
  logic [7:0] nb;
  logic is_m, sec_hit, wr_ok, sec_wr, exec_block, rsvd_rw;
  logic unused_hi;

  for (genvar i = 0; i < NUM_ENTRIES; i++) begin : g_ent
    assign locked[i]   = entry_cfg[8*i+7];
    assign cfg_hit[i]  = csr_addr == CFG_BASE + 12'(i);
    assign addr_hit[i] = csr_addr == ADDR_BASE + 12'(i);
    assign cfg_we[i]   = wr_ok & cfg_hit[i] & (~locked[i] | sec_bypass) & ~exec_block;
    assign addr_we[i]  = wr_ok & addr_hit[i] & (~locked[i] | sec_bypass);
  end

  assign nb        = csr_wdata[7:0];
  assign unused_hi = ^csr_wdata[XLEN-1:8];
  assign is_m      = csr_priv == 2'b11;
  assign sec_hit   = csr_addr == SEC_ADDR;
  assign wr_ok     = csr_we & is_m;
  assign sec_wr    = wr_ok & sec_hit;
  assign illegal   = csr_we & ~is_m & (sec_hit | (|cfg_hit) | (|addr_hit));

  assign rsvd_rw    = nb[1] & ~nb[0];
  assign exec_block = sec_lockdown & ~sec_bypass & nb[7] &
                      (rsvd_rw | (nb[2] & ~(nb[1] & nb[0])));
  assign cfg_wbyte  = (!sec_lockdown && rsvd_rw) ? {nb[7:2], 1'b0, nb[0]} : nb;

  if (LOCKDOWN_MODE == MODE_ZERO) begin : g_ld0
    assign sec_lockdown = 1'b0;
  end else if (LOCKDOWN_MODE == MODE_ONE) begin : g_ld1
    assign sec_lockdown = 1'b1;
  end else begin : g_lds
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)                     sec_lockdown <= 1'b0;
      else if (sec_wr && csr_wdata[0]) sec_lockdown <= 1'b1;
  end

  if (ALLOWLIST_MODE == MODE_ZERO) begin : g_al0
    assign sec_allowlist = 1'b0;
  end else if (ALLOWLIST_MODE == MODE_ONE) begin : g_al1
    assign sec_allowlist = 1'b1;
  end else begin : g_als
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)                     sec_allowlist <= 1'b0;
      else if (sec_wr && csr_wdata[1]) sec_allowlist <= 1'b1;
  end

  if (BYPASS_WRITABLE) begin : g_bpw
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) sec_bypass <= 1'b0;
      else if (sec_wr && !(!sec_bypass && (|locked))) sec_bypass <= csr_wdata[2];
  end else begin : g_bp0
    assign sec_bypass = 1'b0;
  end
endmodule

// File: rtl/sec_cfg_lock_chk.sv
module sec_cfg_lock_chk #(
  parameter int NUM_ENTRIES = 8
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic [8*NUM_ENTRIES-1:0] entry_cfg,
  input logic                     illegal,
  input logic [NUM_ENTRIES-1:0]   cfg_we,
  input logic [NUM_ENTRIES-1:0]   addr_we,
  input logic                     sec_lockdown,
  input logic                     sec_allowlist,
  input logic                     sec_bypass
);
  logic [NUM_ENTRIES-1:0] lk;
  for (genvar i = 0; i < NUM_ENTRIES; i++) begin : g_lk
    assign lk[i] = entry_cfg[8*i+7];
  end

  AST_LOCKDOWN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    sec_lockdown |=> sec_lockdown); // R2
  AST_ALLOWLIST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    sec_allowlist |=> sec_allowlist); // R2
  AST_BYPASS_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (!sec_bypass && (|lk)) |=> !sec_bypass); // R4
  AST_ILLEGAL_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> (cfg_we == '0 && addr_we == '0)); // R5
  AST_ILLEGAL_HOLDS_STATE: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |=> $stable({sec_lockdown, sec_allowlist, sec_bypass})); // R5
  AST_LOCKED_CFG_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    !sec_bypass |-> ((cfg_we & lk) == '0)); // R6
  AST_LOCKED_ADDR_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    !sec_bypass |-> ((addr_we & lk) == '0)); // R6
  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cfg_we, addr_we})); // R9
endmodule

bind sec_cfg_lock sec_cfg_lock_chk #(.NUM_ENTRIES(NUM_ENTRIES)) u_chk (
  .clk(clk), .rst_n(rst_n), .entry_cfg(entry_cfg), .illegal(illegal),
  .cfg_we(cfg_we), .addr_we(addr_we), .sec_lockdown(sec_lockdown),
  .sec_allowlist(sec_allowlist), .sec_bypass(sec_bypass));

// File: tb/sec_cfg_lock_test.sv
module sec_cfg_lock_test;
  localparam int CLK_PERIOD = 10;
  localparam int N = 8;
  localparam logic [11:0] SEC = 12'h747, CFGB = 12'h3A0, ADRB = 12'h3B0;
  // {L,R,W,X, accepted under lockdown with bypass clear}
  localparam logic [4:0] FILT_VEC [16] = '{
    5'b0000_1, 5'b0001_1, 5'b0010_1, 5'b0011_1,
    5'b0100_1, 5'b0101_1, 5'b0110_1, 5'b0111_1,
    5'b1000_1, 5'b1001_0, 5'b1010_0, 5'b1011_0,
    5'b1100_1, 5'b1101_0, 5'b1110_1, 5'b1111_1};

  logic clk = 0, rst_n = 0, csr_we = 0;
  logic [11:0] csr_addr = '0;
  logic [63:0] csr_wdata = '0;
  logic [1:0]  csr_priv = 2'b11;
  logic [8*N-1:0] entry_cfg = '0;
  logic ld, al, bp, ill, f_ld, f_al, f_bp, f_ill;
  logic [N-1:0] cwe, awe, f_cwe, f_awe;
  logic [7:0] wb, f_wb;
  int total = 0, bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sec_cfg_lock uut (.clk(clk), .rst_n(rst_n), .csr_we(csr_we), .csr_addr(csr_addr),
    .csr_wdata(csr_wdata), .csr_priv(csr_priv), .entry_cfg(entry_cfg),
    .sec_lockdown(ld), .sec_allowlist(al), .sec_bypass(bp), .cfg_we(cwe),
    .cfg_wbyte(wb), .addr_we(awe), .illegal(ill));

  sec_cfg_lock #(.LOCKDOWN_MODE(1), .ALLOWLIST_MODE(0), .BYPASS_WRITABLE(1'b0)) uut_fixed (
    .clk(clk), .rst_n(rst_n), .csr_we(csr_we), .csr_addr(csr_addr),
    .csr_wdata(csr_wdata), .csr_priv(csr_priv), .entry_cfg(entry_cfg),
    .sec_lockdown(f_ld), .sec_allowlist(f_al), .sec_bypass(f_bp), .cfg_we(f_cwe),
    .cfg_wbyte(f_wb), .addr_we(f_awe), .illegal(f_ill));

  task automatic chk(string req, logic [63:0] got, logic [63:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic put(logic [11:0] a, logic [63:0] d, logic [1:0] p);
    @(negedge clk);
    csr_we = 1; csr_addr = a; csr_wdata = d; csr_priv = p;
    #1;
  endtask

  task automatic idle();
    @(negedge clk);
    csr_we = 0; csr_priv = 2'b11;
    #1;
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    chk("R1 reset bits", {ld, al, bp}, 3'b000);
    chk("R3 fixed reset bits", {f_ld, f_al, f_bp}, 3'b100);

    put(CFGB + 12'd3, 64'h0F, 2'b11);
    chk("R9 cfg strobe", cwe, 8'b0000_1000);
    chk("R9 no addr strobe", awe, 8'h00);
    chk("R9 byte passed", wb, 8'h0F);
    put(ADRB + 12'd5, 64'h1234, 2'b11);
    chk("R9 addr strobe", {cwe, awe}, {8'h00, 8'b0010_0000});

    put(CFGB, 64'h0A, 2'b11);
    chk("R8 reserved RW cleared", {cwe[0], wb}, {1'b1, 8'h08});

    put(SEC, 64'h7, 2'b00);
    chk("R5 illegal sec write", {ill, cwe, awe}, {1'b1, 16'h0});
    put(CFGB, 64'h01, 2'b01);
    chk("R5 illegal cfg write", {ill, cwe}, {1'b1, 8'h00});
    idle();
    chk("R5 state unchanged", {ld, al, bp}, 3'b000);

    put(SEC, 64'h4, 2'b11); idle();
    chk("R4 bypass set", bp, 1'b1);
    put(SEC, 64'h0, 2'b11); idle();
    chk("R4 bypass cleared", bp, 1'b0);

    put(SEC, 64'h5, 2'b11); idle();
    chk("R2 lockdown set", {ld, al, bp}, 3'b101);
    put(CFGB + 12'd2, 64'h8C, 2'b11);
    chk("R7 exec rule allowed with bypass", cwe, 8'b0000_0100);
    entry_cfg = 64'h0000_0000_0000_8000;
    put(CFGB + 12'd1, 64'h09, 2'b11);
    chk("R6 locked cfg with bypass", cwe, 8'b0000_0010);
    put(ADRB + 12'd1, 64'h55, 2'b11);
    chk("R6 locked addr with bypass", awe, 8'b0000_0010);
    put(SEC, 64'h1, 2'b11); idle();
    chk("R4 bypass cleared while locked", {ld, bp}, 2'b10);
    put(SEC, 64'h0, 2'b11); idle();
    chk("R2 lockdown stays", ld, 1'b1);
    put(SEC, 64'h2, 2'b11); idle();
    put(SEC, 64'h0, 2'b11); idle();
    chk("R2 both sticky", {ld, al}, 2'b11);

    put(CFGB + 12'd1, 64'h09, 2'b11);
    chk("R6 locked cfg dropped", cwe, 8'h00);
    put(ADRB + 12'd1, 64'h55, 2'b11);
    chk("R6 locked addr dropped", awe, 8'h00);
    put(CFGB + 12'd0, 64'h09, 2'b11);
    chk("R6 unlocked neighbour accepted", cwe, 8'b0000_0001);
    put(SEC, 64'h4, 2'b11); idle();
    chk("R4 bypass frozen by lock", bp, 1'b0);

    entry_cfg = '0;
    for (int k = 0; k < 16; k++) begin
      logic [3:0] lrwx;
      logic [7:0] b;
      lrwx = FILT_VEC[k][4:1];
      b = {lrwx[3], 2'b00, 2'b01, lrwx[0], lrwx[1], lrwx[2]};
      put(CFGB + 12'd2, {56'h0, b}, 2'b11);
      chk("R7 exec filter", cwe, FILT_VEC[k][0] ? 8'b0000_0100 : 8'h00);
      chk("R8 byte unchanged under lockdown", wb, b);
    end

    put(SEC, 64'h7, 2'b11); idle();
    chk("R4 bypass settable after unlock", {ld, al, bp}, 3'b111);
    chk("R3 fixed bits hold", {f_ld, f_al, f_bp}, 3'b100);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule